// File: doc/BRIEF.md
# Dual-Sensor Card Presence Tracker

This block decides whether a removable card sits in each of its sockets. Every socket has two card-detect contacts that can close or open a few cycles apart while a card slides in or out. The contacts are synchronised. Any movement of a socket's contact pattern latches a change bit that raises a status interrupt. Software clears that bit by writing ones to it.

Alongside the interrupt path, the block keeps a recorded contact pattern for each socket. When a change bit is set and the live pattern differs from the recorded one, the socket is marked pending. A single service stage then handles one pending socket per cycle, lowest index first. It compares the live pattern with the recorded pattern as a two-bit number and classifies the move as an insertion (larger) or a removal (smaller).

Each socket also has a busy flag, which holds the card-present state that downstream logic acts on. A one-cycle attach pulse is issued only on an insertion that finds the flag clear. A one-cycle detach pulse is issued only on a removal that finds it set. A half-seated card therefore counts as an intermediate value and is not filtered away.

Top module: `card_presence_tracker`

## Requirements
- R1: Each detect input passes through SYNC_STAGES flip-flops (default 2) before use; the socket's sense value is the two-bit number {second contact, first contact}, so the first contact is bit 0 and the second contact is bit 1.
- R2: After warm-up, a socket's change bit (chg_o) is set whenever its synchronised sense value differs from the value one cycle earlier; irq_o is high while any change bit is set.
- R3: A cycle with ack_we_i high clears every change bit whose ack_mask_i bit is 1; change bits whose mask bit is 0 keep their value.
- R4: A socket becomes pending only while its change bit is set and its live sense value differs from its recorded value; a sense excursion that is gone before the change bit is visible queues nothing.
- R5: If a serviced socket's live sense value is numerically greater than its recorded value, the recorded value takes the live value; if busy was clear it is set and attach_o pulses for that socket, otherwise no pulse is issued.
- R6: If a serviced socket's live sense value is numerically smaller than its recorded value, the recorded value takes the live value; if busy was set it is cleared and detach_o pulses for that socket, otherwise no pulse is issued.
- R7: Pending sockets are serviced lowest index first, one per cycle, so that at most one attach or detach pulse is high in any cycle; the serviced socket's pending bit is cleared.
- R8: During reset all outputs are 0; once the synchronisers have filled, each socket whose sense value is non-zero is attached (busy set, one attach pulse) without setting any change bit.
- R9: A serviced socket whose live sense value equals its recorded value produces no pulse and leaves busy unchanged.
- R10: Every attach and detach pulse is exactly one clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| det_a_i | input | NUM_SOCK | First card-detect contact per socket, raw, high when closed |
| det_b_i | input | NUM_SOCK | Second card-detect contact per socket, raw, high when closed |
| ack_we_i | input | 1 | Status write strobe for change-bit acknowledge |
| ack_mask_i | input | NUM_SOCK | Write-one-to-clear mask applied to the change bits |
| attach_o | output | NUM_SOCK | One-cycle insertion pulse per socket |
| detach_o | output | NUM_SOCK | One-cycle removal pulse per socket |
| busy_o | output | NUM_SOCK | Card-present flag per socket |
| chg_o | output | NUM_SOCK | Latched contact-change bit per socket |
| irq_o | output | 1 | Status-change interrupt, OR of all change bits |

## Verification
The assertions assume that the detect contacts are held steady while reset is released, that the acknowledge strobe is only driven after reset, and that contacts change slowly compared with the clock. Under that assumption a socket is never re-serviced in the cycle right after it is serviced. The stimulus changes contacts and the acknowledge strobe only at falling edges and keeps every contact setting for several cycles. The exception is a set of deliberate one- and two-cycle excursions, which check the pending and equal-value rules. Every scenario waits until the pulses have settled before the next one starts.

// File: rtl/cpt_pkg.sv
package cpt_pkg;
    localparam int SENSE_W = 2;
    typedef logic [SENSE_W-1:0] sense_t;
endpackage

// File: rtl/cpt_sync.sv
module cpt_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = d_i;
        for (int k = 1; k < STAGES; k++) begin
            stg_d[k] = stg_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cpt_chg_latch.sv
module cpt_chg_latch
    import cpt_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   armed_i,
    input  sense_t cur_i,
    input  logic   clr_i,
    output logic   chg_o
);
    typedef struct packed {
        sense_t prev;
        logic   chg;
    } lat_t;

    lat_t l_d, l_q;

    always_comb begin
        l_d      = l_q;
        l_d.prev = cur_i;
        if (clr_i)                              l_d.chg = 1'b0;
        if (armed_i && (cur_i != l_q.prev))     l_d.chg = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    assign chg_o = l_q.chg;

    // R3: a change bit only drops after an acknowledge aimed at it
    p_clear_by_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chg_o) |-> $past(clr_i));

    // R2: a change bit is never raised before warm-up completes
    p_set_when_armed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chg_o) |-> $past(armed_i));
endmodule

// File: rtl/cpt_service.sv
module cpt_service
    import cpt_pkg::*;
#(
    parameter int NUM_SOCK    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  sense_t [NUM_SOCK-1:0] cur_i,
    input  logic   [NUM_SOCK-1:0] chg_i,
    output logic                  armed_o,
    output logic   [NUM_SOCK-1:0] attach_o,
    output logic   [NUM_SOCK-1:0] detach_o,
    output logic   [NUM_SOCK-1:0] busy_o
);
    localparam int WARM_MAX = SYNC_STAGES + 1;
    localparam int WARM_W   = $clog2(WARM_MAX + 1);

    typedef struct packed {
        logic [WARM_W-1:0]     warm;
        logic [NUM_SOCK-1:0]   pend;
        logic [NUM_SOCK-1:0]   busy;
        sense_t [NUM_SOCK-1:0] rec;
        logic [NUM_SOCK-1:0]   att;
        logic [NUM_SOCK-1:0]   det;
    } svc_t;

    svc_t s_d, s_q;
    logic priming, armed, done;

    assign priming = (s_q.warm == WARM_W'(SYNC_STAGES));
    assign armed   = (s_q.warm == WARM_W'(WARM_MAX));

    always_comb begin
        s_d     = s_q;
        s_d.att = '0;
        s_d.det = '0;
        done    = 1'b0;
        if (!armed) s_d.warm = s_q.warm + 1'b1;

        // queue sockets whose live value moved away from the record
        for (int i = 0; i < NUM_SOCK; i++) begin
            if ((priming || (armed && chg_i[i])) && (cur_i[i] != s_q.rec[i]))
                s_d.pend[i] = 1'b1;
        end

        // service the lowest pending socket only
        for (int i = 0; i < NUM_SOCK; i++) begin
            if (s_q.pend[i] && !done) begin
                done        = 1'b1;
                s_d.pend[i] = 1'b0;
                if (cur_i[i] > s_q.rec[i]) begin
                    s_d.rec[i] = cur_i[i];
                    if (!s_q.busy[i]) begin
                        s_d.busy[i] = 1'b1;
                        s_d.att[i]  = 1'b1;
                    end
                end else if (cur_i[i] < s_q.rec[i]) begin
                    s_d.rec[i] = cur_i[i];
                    if (s_q.busy[i]) begin
                        s_d.busy[i] = 1'b0;
                        s_d.det[i]  = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign armed_o  = armed;
    assign attach_o = s_q.att;
    assign detach_o = s_q.det;
    assign busy_o   = s_q.busy;

    // R7: never more than one card event per cycle
    p_single_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({attach_o, detach_o}) <= 1);

    for (genvar g = 0; g < NUM_SOCK; g++) begin : g_chk
        // R5: an attach coincides with busy rising
        p_attach_sets_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
            attach_o[g] |-> $rose(busy_o[g]));
        // R5: busy only rises together with an attach
        p_busy_rise_has_attach_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(busy_o[g]) |-> attach_o[g]);
        // R6: a detach coincides with busy falling
        p_detach_clears_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
            detach_o[g] |-> $fell(busy_o[g]));
        // R10: pulses last one cycle
        p_pulse_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (attach_o[g] || detach_o[g]) |=> !(attach_o[g] || detach_o[g]));
    end
endmodule

// File: rtl/card_presence_tracker.sv
module card_presence_tracker
    import cpt_pkg::*;
#(
    parameter int NUM_SOCK    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SOCK-1:0] det_a_i,
    input  logic [NUM_SOCK-1:0] det_b_i,
    input  logic                ack_we_i,
    input  logic [NUM_SOCK-1:0] ack_mask_i,
    output logic [NUM_SOCK-1:0] attach_o,
    output logic [NUM_SOCK-1:0] detach_o,
    output logic [NUM_SOCK-1:0] busy_o,
    output logic [NUM_SOCK-1:0] chg_o,
    output logic                irq_o
);
    localparam int SYNC_W = 2 * NUM_SOCK;

    logic [SYNC_W-1:0]     det_sync;
    sense_t [NUM_SOCK-1:0] cur;
    logic                  armed;

    cpt_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({det_b_i, det_a_i}),
        .q_o   (det_sync)
    );

    for (genvar g = 0; g < NUM_SOCK; g++) begin : g_sock
        assign cur[g] = {det_sync[NUM_SOCK + g], det_sync[g]};

        cpt_chg_latch u_latch (
            .clk     (clk),
            .rst_n   (rst_n),
            .armed_i (armed),
            .cur_i   (cur[g]),
            .clr_i   (ack_we_i && ack_mask_i[g]),
            .chg_o   (chg_o[g])
        );
    end

    cpt_service #(.NUM_SOCK(NUM_SOCK), .SYNC_STAGES(SYNC_STAGES)) u_svc (
        .clk      (clk),
        .rst_n    (rst_n),
        .cur_i    (cur),
        .chg_i    (chg_o),
        .armed_o  (armed),
        .attach_o (attach_o),
        .detach_o (detach_o),
        .busy_o   (busy_o)
    );

    assign irq_o = |chg_o;

    // R2: interrupt tracks the set of latched change bits
    p_irq_needs_chg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (chg_o != '0));
endmodule

// File: tb/card_presence_tracker_tb.sv
module card_presence_tracker_tb;
    localparam int N = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] det_a = '0, det_b = '0;
    logic         ack_we = 1'b0;
    logic [N-1:0] ack_mask = '0;
    logic [N-1:0] attach, detach, busy, chg;
    logic         irq;

    int checks = 0, failures = 0;
    int cyc = 0;
    int att_cnt [N];
    int det_cnt [N];
    int att_cyc [N];
    int det_cyc [N];
    int multi_cnt = 0;

    always #2 clk = ~clk;

    card_presence_tracker #(.NUM_SOCK(N), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .det_a_i(det_a), .det_b_i(det_b),
        .ack_we_i(ack_we), .ack_mask_i(ack_mask),
        .attach_o(attach), .detach_o(detach), .busy_o(busy),
        .chg_o(chg), .irq_o(irq)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < N; i++) begin
                if (attach[i]) begin att_cnt[i]++; att_cyc[i] = cyc; end
                if (detach[i]) begin det_cnt[i]++; det_cyc[i] = cyc; end
            end
            if ($countones({attach, detach}) > 1) multi_cnt++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_counts();
        for (int i = 0; i < N; i++) begin
            att_cnt[i] = 0; det_cnt[i] = 0;
        end
    endtask

    task automatic set_sense(input int s, input logic [1:0] v);
        @(negedge clk);
        det_a[s] = v[0];
        det_b[s] = v[1];
    endtask

    task automatic settle();
        repeat (10) @(negedge clk);
    endtask

    task automatic do_ack(input logic [N-1:0] m);
        @(negedge clk);
        ack_we = 1'b1; ack_mask = m;
        @(negedge clk);
        ack_we = 1'b0; ack_mask = '0;
    endtask

    task automatic excursion(input int s, input logic [1:0] v, input logic [1:0] back, input int k);
        @(negedge clk);
        det_a[s] = v[0]; det_b[s] = v[1];
        repeat (k) @(negedge clk);
        det_a[s] = back[0]; det_b[s] = back[1];
    endtask

    // R8: reset values and attach of a card already seated
    task automatic t_reset();
        det_a = 2'b01; det_b = 2'b01;
        clear_counts();
        repeat (3) @(negedge clk);
        chk({attach, detach, busy, chg, irq} == '0, "R8 outputs in reset",
            int'({attach, detach, busy, chg, irq}), 0);
        rst_n = 1'b1;
        settle();
        chk(att_cnt[0] == 1, "R8 seated socket0 attach count", att_cnt[0], 1);
        chk(att_cnt[1] == 0, "R8 empty socket1 attach count", att_cnt[1], 0);
        chk(busy == 2'b01, "R8 busy after warm-up", busy, 1);
        chk(irq == 1'b0 && chg == '0, "R8 no change bit at warm-up", chg, 0);
    endtask

    // R5 R2 R3 R1: half-seated insertion then full seat
    task automatic t_insert_partial();
        clear_counts();
        set_sense(1, 2'b01);
        settle();
        chk(att_cnt[1] == 1, "R5 partial insert attach", att_cnt[1], 1);
        chk(busy[1] == 1'b1, "R5 busy after partial insert", busy[1], 1);
        chk(chg[1] && irq, "R2 change bit and irq raised", chg[1], 1);
        set_sense(1, 2'b11);
        settle();
        chk(att_cnt[1] == 1, "R5 no second attach while busy", att_cnt[1], 1);
        do_ack(2'b00);
        chk(chg[1] == 1'b1 && irq, "R3 zero mask leaves change bit", chg[1], 1);
        do_ack(2'b01);
        chk(chg[1] == 1'b1, "R3 other socket mask leaves bit", chg[1], 1);
        do_ack(2'b10);
        chk(chg == '0 && !irq, "R3 write-one clears change bit", chg, 0);
    endtask

    // R6 R1: partial withdrawal detaches, empty socket does not pulse again
    task automatic t_removal();
        clear_counts();
        set_sense(1, 2'b10);
        settle();
        chk(det_cnt[1] == 1, "R6 partial removal detach (bit1 still set)", det_cnt[1], 1);
        chk(busy[1] == 1'b0, "R6 busy cleared", busy[1], 0);
        set_sense(1, 2'b00);
        settle();
        chk(det_cnt[1] == 1, "R6 no detach when not busy", det_cnt[1], 1);
        chk(att_cnt[1] == 0, "R6 no attach on removal", att_cnt[1], 0);
        do_ack(2'b11);
    endtask

    // R4 R9: short excursions on a seated socket
    task automatic t_glitch();
        clear_counts();
        set_sense(1, 2'b11);
        settle();
        chk(att_cnt[1] == 1 && busy[1], "R5 full insert attach", att_cnt[1], 1);
        do_ack(2'b10);
        excursion(1, 2'b10, 2'b11, 1);
        settle();
        chk(det_cnt[1] == 0 && att_cnt[1] == 1, "R4 one-cycle dip queues nothing",
            det_cnt[1], 0);
        chk(chg[1] == 1'b1, "R2 dip latched change bit", chg[1], 1);
        do_ack(2'b10);
        excursion(1, 2'b10, 2'b11, 2);
        settle();
        chk(det_cnt[1] == 0 && busy[1], "R9 equal value at service no pulse",
            det_cnt[1], 0);
        do_ack(2'b10);
    endtask

    // R7 R10: both sockets removed in the same cycle
    task automatic t_simultaneous();
        clear_counts();
        multi_cnt = 0;
        @(negedge clk);
        det_a = 2'b00; det_b = 2'b00;
        settle();
        chk(det_cnt[0] == 1 && det_cnt[1] == 1, "R10 one detach cycle per socket",
            det_cnt[0] + det_cnt[1], 2);
        chk(det_cyc[1] - det_cyc[0] == 1, "R7 socket0 first, socket1 next cycle",
            det_cyc[1] - det_cyc[0], 1);
        chk(multi_cnt == 0, "R7 one event per cycle", multi_cnt, 0);
        chk(busy == '0, "R6 both sockets idle", busy, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_insert_partial();
        t_removal();
        t_glitch();
        t_simultaneous();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule